// File: doc/BRIEF.md
# Operand Address Resolver

This block sits in the operand stage of an 8-bit microcontroller core. The core gives it three things: an addressing-mode code, the operand fields of the instruction, and the live register values that addressing needs. These values are the accumulator, the 16-bit data pointer, the two register-bank bits of the status word, and the current contents of the two pointer registers R0 and R1. From these the block works out which memory space the operand lives in and the address inside that space. It also flags requests that the architecture does not allow.

The same byte value at or above 80h resolves to different places depending on the mode. Under direct addressing it reaches the special-function registers, and only the implemented ones are accepted. Under pointer addressing it reaches a separate 128-byte upper RAM. Register operands are moved into one of four 8-byte banks according to the bank bits. Code-space lookups add the accumulator to the data pointer. External data uses the data pointer unchanged. An immediate operand touches no memory and is simply passed through. Every result is registered, so it appears one clock after the inputs.

Top module: `opnd_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs become target 0 (none), address 0 and illegal 0.
- R2: Each result reflects the inputs sampled at the previous rising edge (one cycle of latency).
- R3: Mode code 0 (immediate) gives target 0 (none), address = {8'h00, `opnd_i`} and illegal 0.
- R4: Mode code 1 (register) gives target 1 (lower RAM), address = `bank_i`*8 + `rsel_i`.
- R5: Mode code 2 (direct) with `opnd_i` below 80h gives target 1 (lower RAM), address = `opnd_i`.
- R6: Mode code 2 with `opnd_i` at 80h or above gives target 3 (SFR), address = `opnd_i`, when the address is in the implemented-register list parameter. For any other such address the result is illegal 1, target 0, address 0.
- R7: Mode code 3 (pointer) with `rsel_i` 0 or 1 takes the pointer from `ptr0_i` or `ptr1_i`. A pointer below 80h gives target 1, and a pointer at 80h or above gives target 2 (upper RAM). The address is the pointer in both cases, and an SFR address is never produced.
- R8: Mode code 3 with `rsel_i` from 2 to 7 gives illegal 1, target 0, address 0.
- R9: Mode code 4 (indexed code) gives target 4 (code), address = (`acc_i` + `dptr_i`) mod 65536.
- R10: Mode code 5 (external data) gives target 5 (external data), address = `dptr_i`.
- R11: Mode codes 6 and 7 give illegal 1, target 0, address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Addressing-mode code |
| rsel_i | input | 3 | Register number Rn from the instruction |
| opnd_i | input | 8 | Direct address or immediate byte |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | 16 | Data pointer value |
| bank_i | input | 2 | Register-bank bits from the status word |
| ptr0_i | input | 8 | Current contents of R0 |
| ptr1_i | input | 8 | Current contents of R1 |
| tgt_o | output | 3 | Target space: 0 none, 1 lower RAM, 2 upper RAM, 3 SFR, 4 code, 5 external data |
| addr_o | output | 16 | Resolved address |
| illegal_o | output | 1 | Request not allowed |

## Verification
The bench concentrates on the 80h boundary. It sends bytes 7Fh and 80h, and pointer values above 80h, through both direct and pointer modes. A design that shared one decode for both modes would either send pointer accesses to SFRs or send direct accesses to upper RAM. It also sends unimplemented SFR addresses such as 84h and FFh, and a resolver that did not check the register list would pass those through as legal. The bench also covers pointer requests through R2 to R7, an index sum that carries past FFFFh (where a design without the wrap would get the address wrong), and register operands in bank 3. A lost or doubled pipeline stage would show up as results one cycle off.

// File: rtl/opag_pkg.sv
// Package: shared encodings for the operand address resolver.
// Assumes: mode and target codes are fixed by the core's decode stage.
package opag_pkg;
    localparam logic [2:0] MODE_IMM  = 3'd0;
    localparam logic [2:0] MODE_REG  = 3'd1;
    localparam logic [2:0] MODE_DIR  = 3'd2;
    localparam logic [2:0] MODE_PTR  = 3'd3;
    localparam logic [2:0] MODE_CODE = 3'd4;
    localparam logic [2:0] MODE_XDAT = 3'd5;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_LRAM  = 3'd1,
        TGT_URAM  = 3'd2,
        TGT_SFR   = 3'd3,
        TGT_CODE  = 3'd4,
        TGT_XDATA = 3'd5
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        logic [15:0] addr;
        logic        ill;
    } res_t;
endpackage

// File: rtl/opag_sfr_match.sv
// Module: compares a byte address against a parameter list of implemented
// special-function registers, one comparator per entry.
// Assumes: LIST holds N_SFR byte entries, entry i at bits [8i+7:8i].
module opag_sfr_match #(
    parameter int unsigned N_SFR = 21,
    parameter logic [8*N_SFR-1:0] LIST = '0
) (
    input  logic [7:0] addr_i,
    output logic       hit_o
);
    logic [N_SFR-1:0] eq;

    // One equality comparator per listed register address.
    for (genvar i = 0; i < N_SFR; i++) begin : g_cmp
        assign eq[i] = (addr_i == LIST[i*8 +: 8]);
    end

    // Any comparator match means the address is implemented.
    assign hit_o = |eq;
endmodule

// File: rtl/opag_rn_map.sv
// Module: relocates register Rn into internal RAM using the bank bits.
// Assumes: banks are 2**RN_W bytes long and start at address 0.
module opag_rn_map #(
    parameter int unsigned RN_W = 3,
    parameter int unsigned BK_W = 2,
    parameter int unsigned DW   = 8
) (
    input  logic [BK_W-1:0] bank_i,
    input  logic [RN_W-1:0] rn_i,
    output logic [DW-1:0]   ram_addr_o
);
    localparam int unsigned PAD = DW - RN_W - BK_W;

    // Address is bank times bank size plus register number.
    assign ram_addr_o = {{PAD{1'b0}}, bank_i, rn_i};
endmodule

// File: rtl/opag_index_add.sv
// Module: forms an indexed code address as base plus unsigned offset.
// Assumes: the sum wraps at 2**AW, with no carry out kept.
module opag_index_add #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] off_i,
    output logic [AW-1:0] sum_o
);
    // Zero-extend the offset and add; the top carry is dropped.
    assign sum_o = base_i + {{(AW-DW){1'b0}}, off_i};
endmodule

// File: rtl/opnd_addr_gen.sv
// Module: top of the operand address resolver. Decodes the mode, picks the
// target space and address, flags illegal requests, registers the result.
// Assumes: pointer register contents and bank bits are current when sampled;
// illegal requests are reported with target none and address zero.
module opnd_addr_gen
    import opag_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 16,
    parameter int unsigned RN_W  = 3,
    parameter int unsigned BK_W  = 2,
    parameter int unsigned N_SFR = 21,
    parameter logic [8*N_SFR-1:0] SFR_LIST = {
        8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89,
        8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99,
        8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'hD0, 8'hE0, 8'hF0}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode_i,
    input  logic [RN_W-1:0] rsel_i,
    input  logic [DW-1:0]   opnd_i,
    input  logic [DW-1:0]   acc_i,
    input  logic [AW-1:0]   dptr_i,
    input  logic [BK_W-1:0] bank_i,
    input  logic [DW-1:0]   ptr0_i,
    input  logic [DW-1:0]   ptr1_i,
    output logic [2:0]      tgt_o,
    output logic [AW-1:0]   addr_o,
    output logic            illegal_o
);
    localparam int unsigned XW = AW - DW;

    logic          sfr_hit;
    logic [DW-1:0] rn_addr;
    logic [AW-1:0] code_addr;
    logic [DW-1:0] ptr_val;
    logic          ptr_ok;
    res_t          res_d, res_q;

    opag_sfr_match #(.N_SFR(N_SFR), .LIST(SFR_LIST)) u_sfr (
        .addr_i (opnd_i),
        .hit_o  (sfr_hit)
    );

    opag_rn_map #(.RN_W(RN_W), .BK_W(BK_W), .DW(DW)) u_rn (
        .bank_i     (bank_i),
        .rn_i       (rsel_i),
        .ram_addr_o (rn_addr)
    );

    opag_index_add #(.AW(AW), .DW(DW)) u_idx (
        .base_i (dptr_i),
        .off_i  (acc_i),
        .sum_o  (code_addr)
    );

    // Pointer selection: only R0 and R1 may serve as pointers.
    always_comb begin
        ptr_ok  = (rsel_i[RN_W-1:1] == '0);
        ptr_val = rsel_i[0] ? ptr1_i : ptr0_i;
    end

    // Mode decode: choose target space and address, or flag illegal.
    always_comb begin
        res_d = '{tgt: TGT_NONE, addr: '0, ill: 1'b0};
        unique case (mode_i)
            MODE_IMM: res_d.addr = {{XW{1'b0}}, opnd_i};
            MODE_REG: begin
                res_d.tgt  = TGT_LRAM;
                res_d.addr = {{XW{1'b0}}, rn_addr};
            end
            MODE_DIR: begin
                if (!opnd_i[DW-1]) begin
                    res_d.tgt  = TGT_LRAM;
                    res_d.addr = {{XW{1'b0}}, opnd_i};
                end else if (sfr_hit) begin
                    res_d.tgt  = TGT_SFR;
                    res_d.addr = {{XW{1'b0}}, opnd_i};
                end else begin
                    res_d.ill = 1'b1;
                end
            end
            MODE_PTR: begin
                if (ptr_ok) begin
                    res_d.tgt  = ptr_val[DW-1] ? TGT_URAM : TGT_LRAM;
                    res_d.addr = {{XW{1'b0}}, ptr_val};
                end else begin
                    res_d.ill = 1'b1;
                end
            end
            MODE_CODE: begin
                res_d.tgt  = TGT_CODE;
                res_d.addr = code_addr;
            end
            MODE_XDAT: begin
                res_d.tgt  = TGT_XDATA;
                res_d.addr = dptr_i;
            end
            default: res_d.ill = 1'b1;
        endcase
    end

    // Output register: one cycle latency, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '{tgt: TGT_NONE, addr: '0, ill: 1'b0};
        else        res_q <= res_d;
    end

    assign tgt_o     = res_q.tgt;
    assign addr_o    = res_q.addr;
    assign illegal_o = res_q.ill;

    // R8: a pointer request through R2..R7 is flagged one cycle later.
    a_r8_bad_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PTR && rsel_i[RN_W-1:1] != '0) |=> illegal_o);

    // R7: pointer at or above the boundary never lands in SFR space.
    a_r7_ptr_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PTR && rsel_i[RN_W-1:1] == '0 &&
         (rsel_i[0] ? ptr1_i[DW-1] : ptr0_i[DW-1]))
        |=> (tgt_o == TGT_URAM));

    // R5: low direct addresses go to lower RAM unchanged.
    a_r5_direct_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_DIR && !opnd_i[DW-1])
        |=> (tgt_o == TGT_LRAM && addr_o == {{XW{1'b0}}, $past(opnd_i)}));

    // R6: any SFR result carries an address in the upper half of the byte range.
    a_r6_sfr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_SFR) |-> (addr_o[AW-1:DW] == '0 && addr_o[DW-1]));

    // R9: indexed code address is the wrapped sum of the sampled operands.
    a_r9_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_CODE)
        |=> (tgt_o == TGT_CODE &&
             addr_o == AW'($past(dptr_i) + {{XW{1'b0}}, $past(acc_i)})));

    // R11: unassigned mode codes are flagged.
    a_r11_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i > MODE_XDAT) |=> illegal_o);

    // R6 / R8 / R11: an illegal result never names a target or address.
    a_r8_ill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (tgt_o == TGT_NONE && addr_o == '0));
endmodule

// File: tb/sim_opnd_addr_gen.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a bench-side model of the requirements.
module sim_opnd_addr_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  mode_i, rsel_i;
    logic [7:0]  opnd_i, acc_i, ptr0_i, ptr1_i;
    logic [15:0] dptr_i;
    logic [1:0]  bank_i;
    logic [2:0]  tgt_o;
    logic [15:0] addr_o;
    logic        illegal_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    opnd_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rsel_i(rsel_i),
        .opnd_i(opnd_i), .acc_i(acc_i), .dptr_i(dptr_i), .bank_i(bank_i),
        .ptr0_i(ptr0_i), .ptr1_i(ptr1_i), .tgt_o(tgt_o), .addr_o(addr_o),
        .illegal_o(illegal_o)
    );

    typedef struct packed {
        logic [2:0]  t;
        logic [15:0] a;
        logic        i;
    } exp_t;

    function automatic bit sfr_known(input logic [7:0] a);
        case (a)
            8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A,
            8'h8B, 8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8,
            8'hB0, 8'hB8, 8'hD0, 8'hE0, 8'hF0: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic exp_t model();
        exp_t e = '{t: 3'd0, a: 16'd0, i: 1'b0};
        logic [7:0] p;
        case (mode_i)
            3'd0: e.a = {8'h00, opnd_i};
            3'd1: begin e.t = 3'd1; e.a = 16'(bank_i) * 16'd8 + 16'(rsel_i); end
            3'd2: begin
                if (opnd_i < 8'h80) begin e.t = 3'd1; e.a = {8'h00, opnd_i}; end
                else if (sfr_known(opnd_i)) begin e.t = 3'd3; e.a = {8'h00, opnd_i}; end
                else e.i = 1'b1;
            end
            3'd3: begin
                if (rsel_i > 3'd1) e.i = 1'b1;
                else begin
                    p = (rsel_i == 3'd1) ? ptr1_i : ptr0_i;
                    e.t = (p >= 8'h80) ? 3'd2 : 3'd1;
                    e.a = {8'h00, p};
                end
            end
            3'd4: begin e.t = 3'd4; e.a = 16'((17'(dptr_i) + 17'(acc_i)) % 17'h10000); end
            3'd5: begin e.t = 3'd5; e.a = dptr_i; end
            default: e.i = 1'b1;
        endcase
        return e;
    endfunction

    function automatic string tag_of();
        case (mode_i)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return (opnd_i < 8'h80) ? "R5" : "R6";
            3'd3: return (rsel_i > 3'd1) ? "R8" : "R7";
            3'd4: return "R9";
            3'd5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(input string tag, input exp_t e);
        n_run++;
        if (tgt_o !== e.t || addr_o !== e.a || illegal_o !== e.i) begin
            n_fail++;
            $display("FAIL %s: got tgt=%0d addr=%h ill=%b, expected tgt=%0d addr=%h ill=%b",
                     tag, tgt_o, addr_o, illegal_o, e.t, e.a, e.i);
        end
    endtask

    // Apply one request at the falling edge and check it one edge later (R2).
    task automatic step(input logic [2:0] m, input logic [2:0] r, input logic [7:0] o,
                        input logic [7:0] a, input logic [15:0] d, input logic [1:0] b,
                        input logic [7:0] p0, input logic [7:0] p1);
        exp_t e;
        string tg;
        @(negedge clk);
        mode_i = m; rsel_i = r; opnd_i = o; acc_i = a;
        dptr_i = d; bank_i = b; ptr0_i = p0; ptr1_i = p1;
        e  = model();
        tg = tag_of();
        @(posedge clk); #1;
        compare({tg, "/R2"}, e);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] sfr_pick [0:3];
        sfr_pick[0] = 8'hD0; sfr_pick[1] = 8'hE0; sfr_pick[2] = 8'h84; sfr_pick[3] = 8'hFF;
        void'($urandom(32'd20251));
        rst_n = 1'b0;
        mode_i = 3'd4; rsel_i = 3'd7; opnd_i = 8'hFF; acc_i = 8'hFF;
        dptr_i = 16'hFFFF; bank_i = 2'd3; ptr0_i = 8'hFF; ptr1_i = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset", '{t: 3'd0, a: 16'd0, i: 1'b0});
        @(negedge clk); rst_n = 1'b1;

        // Directed corners.
        step(3'd0, 3'd0, 8'hA5, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R3
        step(3'd1, 3'd7, 8'h00, 8'h00, 16'h0000, 2'd3, 8'h00, 8'h00); // R4 -> 1Fh
        step(3'd1, 3'd0, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R4 -> 00h
        step(3'd2, 3'd0, 8'h7F, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R5 edge
        step(3'd2, 3'd0, 8'h80, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R6 edge SFR
        step(3'd2, 3'd0, 8'h84, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R6 reserved
        step(3'd2, 3'd0, 8'hFF, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R6 reserved top
        step(3'd2, 3'd0, 8'hF0, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R6 listed
        step(3'd3, 3'd0, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h80, 8'h10); // R7 upper via R0
        step(3'd3, 3'd1, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h80, 8'h7F); // R7 lower via R1
        step(3'd3, 3'd1, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h00, 8'hE0); // R7 not SFR
        step(3'd3, 3'd2, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h30, 8'h30); // R8
        step(3'd3, 3'd7, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h30, 8'h30); // R8
        step(3'd4, 3'd0, 8'h00, 8'hFF, 16'hFFF0, 2'd0, 8'h00, 8'h00); // R9 wrap
        step(3'd4, 3'd0, 8'h00, 8'h01, 16'h12FF, 2'd0, 8'h00, 8'h00); // R9 carry
        step(3'd5, 3'd0, 8'h00, 8'h55, 16'hBEEF, 2'd0, 8'h00, 8'h00); // R10
        step(3'd6, 3'd0, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R11
        step(3'd7, 3'd0, 8'h00, 8'h00, 16'h0000, 2'd0, 8'h00, 8'h00); // R11

        // Seeded random requests.
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] ob;
            ob = 8'($urandom);
            if (($urandom % 4) == 0) ob = sfr_pick[$urandom % 4];
            step(3'($urandom), 3'($urandom), ob, 8'($urandom), 16'($urandom),
                 2'($urandom), 8'($urandom), 8'($urandom));
        end

        // R1: reset mid-run clears outputs despite an active request.
        @(negedge clk);
        rst_n = 1'b0; mode_i = 3'd5; dptr_i = 16'h1234;
        @(posedge clk); #1;
        compare("R1 mid-run reset", '{t: 3'd0, a: 16'd0, i: 1'b0});
        @(negedge clk); rst_n = 1'b1;
        step(3'd5, 3'd0, 8'h00, 8'h00, 16'h4321, 2'd0, 8'h00, 8'h00); // R10 after reset

        finish_run();
    end
endmodule